// File: doc/BRIEF.md
# Pattern-Replay Clock Divider

This block derives a slower clock from an input clock by replaying a 16-bit waveform pattern, one bit per input cycle. A built-in pattern calculator turns a requested power-of-two divide ratio and a phase delay, counted in input cycles, into the pattern. The pattern is then replayed from bit 0 up to a programmable end index, after which it wraps back to bit 0.

A configuration load strobe captures five things in one rising edge: the divide ratio, the delay, the end index, an enable bit and an edge-select bit. The same edge restarts replay at bit 0. The replayed bit leaves the block either through a register clocked on the rising edge or through one clocked on the falling edge, as the edge-select bit chooses. A divide ratio of 1 cannot be written as one bit per cycle, so for that ratio the input clock is passed straight to the output.

Top module: `clkpat_wavegen`

## Requirements
- R1: A synchronous active-low reset clears the stored pattern and the enable bit, sets the end index to 15 and the replay position to 0. The output reads 0 while reset is held and after reset is released, until a configuration is loaded.
- R2: With the enable bit set, a divide code d in 1..4 (ratio N = 2^d), delay 0, end index 15 and rising-edge output, the output is 1 for the first N/2 input cycles after the load edge and 0 for the next N/2 cycles, and this repeats with period N. In general, pattern bit i is 1 exactly when ((i + 16 - s) mod N) < N/2, where s is the delay.
- R3: A delay s of 1 or 2 postpones the start of the high phase by s input cycles, following the formula in R2. For example, N = 4 with s = 1 gives pattern bits 15..0 = 0110011001100110.
- R4: In the cycle that follows the k-th rising edge after the load edge, the replayed bit is pattern bit (k mod (E+1)), where E is the end index. Replay wraps to bit 0 after bit E.
- R5: With edge select 1 (falling), the output takes its bit at the falling edge that follows the rising edge where the replay position moved. Its waveform is therefore the rising-edge waveform delayed by half an input cycle.
- R6: With the enable bit set and divide code 0, the output equals the input clock. The edge-select bit has no effect in this case.
- R7: With the enable bit clear, the output stays 0 for any pattern.
- R8: A load strobe sets the replay position to 0 and installs the new pattern in the same edge. This holds whatever the current position is, including a position equal to the old end index.
- R9: Divide codes 5 to 7 are treated as code 4 (ratio 16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_load | input | 1 | Captures the cfg_* inputs and restarts replay |
| cfg_div_log2 | input | 3 | Divide code d; ratio is 2^d |
| cfg_shift | input | 2 | Delay of the high phase, in input cycles |
| cfg_end | input | 4 | Last pattern index before wrap |
| cfg_fall | input | 1 | 1 selects falling-edge output, 0 selects rising-edge output |
| cfg_mode | input | 1 | 1 enables pattern replay |
| clk_out | output | 1 | Generated clock |

## Verification
A load strobe and the pointer's own wrap can land on the same rising edge. Both then drive the replay position to 0, but only the load installs a new pattern and end index. The bench provokes this by loading a divide-by-4 pattern with end index 7 and placing a second load, with a different ratio, delay and end index, exactly on the edge where the pointer would wrap. It judges the result by the waveform that follows, which must match the new pattern from bit 1 onward with no leftover cycle of the old one.

The bench also sweeps every divide code, every supported delay and both edge settings. It samples the output once in the high half and once in the low half of each input cycle, and compares each sample with the value given by the arithmetic formula.

// File: rtl/clkpat_pkg.sv
`timescale 1ns/1ps
// Package clkpat_pkg
// Shared types for the pattern-replay clock divider.
package clkpat_pkg;
    // Selects which input clock edge launches the output bit.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_sel_e;
endpackage

// File: rtl/clkpat_builder.sv
`timescale 1ns/1ps
// Module clkpat_builder
// Combinational pattern calculator. For divide code d (ratio N = 2^d) and
// delay s, bit i of the pattern is 1 when ((i + PAT_W - s) mod N) < N/2.
// Assumes PAT_W is a power of two, so every legal N divides PAT_W.
// Codes larger than log2(PAT_W) are clamped. Code 0 raises bypass.
module clkpat_builder #(
    parameter int unsigned PAT_W = 16,
    parameter int unsigned DIV_W = 3,
    parameter int unsigned SH_W  = 2
) (
    input  logic [DIV_W-1:0] div_log2,
    input  logic [SH_W-1:0]  shift,
    output logic [PAT_W-1:0] pattern,
    output logic             bypass
);
    localparam int unsigned MAXL = $clog2(PAT_W);
    localparam int unsigned IW   = MAXL + 1;

    logic [DIV_W-1:0] eff;
    logic [IW-1:0]    mask;
    logic [IW-1:0]    half;

    // Clamp the divide code and derive the index mask and half period.
    always_comb begin
        eff  = (div_log2 > MAXL[DIV_W-1:0]) ? MAXL[DIV_W-1:0] : div_log2;
        mask = (IW'(1) << eff) - IW'(1);
        half = (eff == '0) ? IW'(1) : (IW'(1) << (eff - 1'b1));
    end

    assign bypass = (eff == '0);

    // One comparator per pattern bit, each giving that bit's phase.
    for (genvar i = 0; i < PAT_W; i++) begin : g_bit
        logic [IW-1:0] pos;
        assign pos        = (IW'(i) + IW'(PAT_W) - IW'(shift)) & mask;
        assign pattern[i] = (pos < half);
    end
endmodule

// File: rtl/clkpat_pointer.sv
`timescale 1ns/1ps
// Module clkpat_pointer
// Replay position counter and end-index register. The position steps by one
// on each rising edge and wraps to 0 after the end index. A load sets the
// position to 0 and captures a new end index in the same edge.
module clkpat_pointer #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_end,
    output logic [IDX_W-1:0] ptr_q,
    output logic [IDX_W-1:0] ptr_nxt
);
    logic [IDX_W-1:0] end_q;

    // Next position: restart on load, wrap at the end index, else step.
    always_comb begin
        if (load)
            ptr_nxt = '0;
        else if (ptr_q == end_q)
            ptr_nxt = '0;
        else
            ptr_nxt = ptr_q + 1'b1;
    end

    // Position and end-index registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            end_q <= '1;
        end else begin
            ptr_q <= ptr_nxt;
            if (load)
                end_q <= load_end;
        end
    end

    assert_ptr_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= end_q);
    assert_ptr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ptr_q == end_q) |=> (ptr_q == '0));
    assert_ptr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && ptr_q != end_q) |=> (ptr_q == $past(ptr_q) + 1'b1));
    assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (ptr_q == '0));
    assert_reset_ptr_R1: assert property (@(posedge clk)
        !rst_n |=> (ptr_q == '0));
endmodule

// File: rtl/clkpat_edge_stage.sv
`timescale 1ns/1ps
// Module clkpat_edge_stage
// Two output launch registers: one clocked on the rising edge, one on the
// falling edge. Assumes the caller gives each flop the bit that belongs to
// its launch point. Both flops clear under reset.
module clkpat_edge_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_d,
    input  logic fall_d,
    output logic rise_q,
    output logic fall_q
);
    // Rising-edge launch of the next replayed bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rise_q <= 1'b0;
        else
            rise_q <= rise_d;
    end

    // Falling-edge launch of the current replayed bit.
    always_ff @(negedge clk) begin
        if (!rst_n)
            fall_q <= 1'b0;
        else
            fall_q <= fall_d;
    end
endmodule

// File: rtl/clkpat_wavegen.sv
`timescale 1ns/1ps
// Module clkpat_wavegen
// Top of the pattern-replay clock divider. It holds the configuration
// registers, builds the pattern from the divide code and delay, replays the
// pattern through the pointer and launches the bit on the chosen edge.
// Divide code 0 passes clk_in straight to the output. Assumes configuration
// changes only through cfg_load; no glitch-free switching is attempted.
module clkpat_wavegen
    import clkpat_pkg::*;
#(
    parameter int unsigned PAT_W = 16,
    parameter int unsigned DIV_W = 3,
    parameter int unsigned SH_W  = 2,
    localparam int unsigned IDX_W = $clog2(PAT_W)
) (
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic             cfg_load,
    input  logic [DIV_W-1:0] cfg_div_log2,
    input  logic [SH_W-1:0]  cfg_shift,
    input  logic [IDX_W-1:0] cfg_end,
    input  logic             cfg_fall,
    input  logic             cfg_mode,
    output logic             clk_out
);
    logic [PAT_W-1:0] built_pat;
    logic             built_bypass;
    logic [PAT_W-1:0] pat_q;
    logic [PAT_W-1:0] pat_nxt;
    logic             mode_q;
    logic             bypass_q;
    edge_sel_e        edge_q;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] ptr_nxt;
    logic             rise_q;
    logic             fall_q;

    clkpat_builder #(
        .PAT_W (PAT_W),
        .DIV_W (DIV_W),
        .SH_W  (SH_W)
    ) builder_i (
        .div_log2 (cfg_div_log2),
        .shift    (cfg_shift),
        .pattern  (built_pat),
        .bypass   (built_bypass)
    );

    clkpat_pointer #(
        .IDX_W (IDX_W)
    ) pointer_i (
        .clk      (clk_in),
        .rst_n    (rst_n),
        .load     (cfg_load),
        .load_end (cfg_end),
        .ptr_q    (ptr_q),
        .ptr_nxt  (ptr_nxt)
    );

    // Pattern that holds after this edge: the new one on load.
    assign pat_nxt = cfg_load ? built_pat : pat_q;

    // Configuration registers, captured on the load strobe.
    always_ff @(posedge clk_in) begin
        if (!rst_n) begin
            pat_q    <= '0;
            mode_q   <= 1'b0;
            bypass_q <= 1'b0;
            edge_q   <= EDGE_RISE;
        end else if (cfg_load) begin
            pat_q    <= built_pat;
            mode_q   <= cfg_mode;
            bypass_q <= built_bypass;
            edge_q   <= cfg_fall ? EDGE_FALL : EDGE_RISE;
        end
    end

    clkpat_edge_stage edge_i (
        .clk    (clk_in),
        .rst_n  (rst_n),
        .rise_d (pat_nxt[ptr_nxt]),
        .fall_d (pat_q[ptr_q]),
        .rise_q (rise_q),
        .fall_q (fall_q)
    );

    // Output select: disabled, bypass, or the chosen edge's register.
    always_comb begin
        if (!mode_q)
            clk_out = 1'b0;
        else if (bypass_q)
            clk_out = clk_in;
        else if (edge_q == EDGE_FALL)
            clk_out = fall_q;
        else
            clk_out = rise_q;
    end

    assert_mode_off_R7: assert property (@(posedge clk_in) disable iff (!rst_n)
        !mode_q |-> !clk_out);
    assert_half_duty_R2: assert property (@(posedge clk_in) disable iff (!rst_n)
        (mode_q && !bypass_q) |-> ($countones(pat_q) == PAT_W / 2));
    assert_rise_tracks_R4: assert property (@(posedge clk_in) disable iff (!rst_n)
        (!cfg_load && mode_q && !bypass_q && edge_q == EDGE_RISE)
            |=> (clk_out == pat_q[ptr_q]));
endmodule

// File: tb/clkpat_wavegen_tb_top.sv
`timescale 1ns/1ps
module clkpat_wavegen_tb_top;
    logic       clk_in = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [2:0] cfg_div_log2 = '0;
    logic [1:0] cfg_shift = '0;
    logic [3:0] cfg_end = '0;
    logic       cfg_fall = 1'b0;
    logic       cfg_mode = 1'b0;
    logic       clk_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    clkpat_wavegen dut_i (
        .clk_in       (clk_in),
        .rst_n        (rst_n),
        .cfg_load     (cfg_load),
        .cfg_div_log2 (cfg_div_log2),
        .cfg_shift    (cfg_shift),
        .cfg_end      (cfg_end),
        .cfg_fall     (cfg_fall),
        .cfg_mode     (cfg_mode),
        .clk_out      (clk_out)
    );

    always #10 clk_in = ~clk_in;

    // Expected pattern bit from the requirement formula (R2, R3, R9).
    function automatic bit exp_bit(int d, int s, int i);
        int dd = (d > 4) ? 4 : d;
        int n = 1 << dd;
        return (((i + 16 - s) % n) < (n / 2));
    endfunction

    task automatic chk(bit act, bit exp, string req, string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Called in the low half of a cycle; the next rising edge is the load edge.
    task automatic run_cfg(int d, int s, int e, bit f, bit m, int cycles, string tag);
        string req;
        bit ea, eb;
        if (tag != "")      req = tag;
        else if (!m)        req = "R7";
        else if (d == 0)    req = "R6";
        else if (d > 4)     req = "R9";
        else if (e != 15)   req = "R4";
        else if (f)         req = "R5";
        else if (s != 0)    req = "R3";
        else                req = "R2";
        cfg_div_log2 = 3'(d);
        cfg_shift    = 2'(s);
        cfg_end      = 4'(e);
        cfg_fall     = f;
        cfg_mode     = m;
        cfg_load     = 1'b1;
        @(posedge clk_in);
        #5 cfg_load = 1'b0;
        for (int k = 1; k <= cycles; k++) begin
            @(posedge clk_in);
            #5;
            if (!m)          ea = 1'b0;
            else if (d == 0) ea = 1'b1;
            else if (f)      ea = exp_bit(d, s, (k - 1) % (e + 1));
            else             ea = exp_bit(d, s, k % (e + 1));
            chk(clk_out, ea, req, "high-half sample");
            #10;
            if (!m)          eb = 1'b0;
            else if (d == 0) eb = 1'b0;
            else             eb = exp_bit(d, s, k % (e + 1));
            chk(clk_out, eb, req, "low-half sample");
        end
    endtask

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk_in);
        #15 chk(clk_out, 1'b0, "R1", "output during reset");
        rst_n = 1'b1;
        repeat (2) @(posedge clk_in);
        #15 chk(clk_out, 1'b0, "R1", "output after reset release");

        // Sweep of divide code, delay and edge over the full pattern
        for (int d = 0; d <= 4; d++)
            for (int s = 0; s <= 2; s++)
                for (int f = 0; f <= 1; f++)
                    run_cfg(d, s, 15, f[0], 1'b1, 32, "");

        // R4: shorter end indices
        run_cfg(2, 1, 7, 1'b0, 1'b1, 24, "");
        run_cfg(2, 2, 11, 1'b1, 1'b1, 30, "");
        // R9: clamped divide codes
        run_cfg(6, 1, 15, 1'b0, 1'b1, 34, "");
        run_cfg(7, 0, 15, 1'b1, 1'b1, 34, "");
        // R7: replay disabled
        run_cfg(2, 0, 15, 1'b0, 1'b0, 16, "");

        // R8: load on the wrap edge, then a load in mid-period
        run_cfg(2, 0, 7, 1'b0, 1'b1, 7, "R4");
        run_cfg(3, 1, 15, 1'b0, 1'b1, 20, "R8");
        run_cfg(1, 1, 15, 1'b1, 1'b1, 18, "R8");

        // R1: reset in the middle of replay clears the output
        run_cfg(2, 1, 15, 1'b0, 1'b1, 5, "R3");
        rst_n = 1'b0;
        @(posedge clk_in);
        #15 chk(clk_out, 1'b0, "R1", "output after mid-run reset");
        rst_n = 1'b1;
        @(posedge clk_in);
        #15 chk(clk_out, 1'b0, "R1", "output after second release");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule